// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch Timer

This block runs the overcurrent timing of one channel of a switching regulator controller. It advances once per switching cycle, marked by a single-clock tick strobe. Each tick it reads a sampled overcurrent comparator bit. While that bit is high, the block suppresses the high-side turn-on for the cycle. The first trip from rest opens a limit window of eight ticks, in which the block only skips pulses. A watch window of eight more ticks follows. Any further overcurrent seen in the watch window latches a shutdown request. If the watch window passes clean, the block returns to rest sixteen ticks after the first trip and can trip again.

A latched fault remains until the enable input is driven low or the bias reset is applied. In memory-tracking mode, the channel whose index matches a parameter has its overcurrent logic switched off. Its outputs stay low and its sequence is held cleared.

Top module: `oc_guard_timer`

## Requirements
- R1: After reset, with the comparator low, skip_hs and fault_req are both 0.
- R2: When the channel is active, skip_hs equals 1 in the same cycle that oc_hit is 1, with no register in between. When oc_hit is 0 and no fault is latched, skip_hs is 0.
- R3: A tick with oc_hit=1 while at rest is tick 1 of a new sequence. During ticks 1 to 8, oc_hit never latches a fault.
- R4: oc_hit=1 on any of ticks 9 to 16 latches the fault. fault_req is 1 after the clock edge of that tick, including tick 16.
- R5: If ticks 9 to 16 all see oc_hit=0, the block is at rest again. A trip on tick 17 starts a fresh sequence, and that sequence only latches on its own ninth tick or later.
- R6: Once latched, fault_req stays 1 and skip_hs stays 1 whatever oc_hit and sw_tick do, until a clear.
- R7: en=0 on a clock edge clears the latch and any running sequence at that edge. The next trip after en returns to 1 starts a fresh sequence.
- R8: When ddr_mode=1 and chan_id equals DDR_OFF_CHAN (default 1), skip_hs is 0 and fault_req is 0 from the next edge on. The channel with the other index keeps working normally in that mode.
- R9: The comparator bit is acted on only in cycles where sw_tick=1. oc_hit held high on clocks without a tick neither trips nor latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (bias reset), released synchronously inside |
| en | input | 1 | Channel enable; low clears the latch and the sequence |
| sw_tick | input | 1 | One-clock strobe per switching cycle |
| oc_hit | input | 1 | Sampled overcurrent comparator bit |
| ddr_mode | input | 1 | Memory-tracking mode flag |
| chan_id | input | CHAN_W | Index of this channel |
| skip_hs | output | 1 | Suppress the high-side turn-on this cycle |
| fault_req | output | 1 | Latched shutdown request for the chip |

## Verification
skip_hs is a combinational result, so it is due in the same cycle as the oc_hit change. The bench reads it one time unit after driving the comparator. fault_req is taken from the state register and changes on the clock edge that ends the tick, or the enable/mode clear. Every tick task therefore drives the strobe one unit after a rising edge, waits for the next edge, and samples one unit after it. The window boundaries are checked by counting ticks in the bench: tick 8 must not latch, ticks 9 and 16 must, and tick 17 after a clean watch window must start over.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

  typedef enum logic [1:0] {
    OCS_REST  = 2'd0,
    OCS_LIMIT = 2'd1,
    OCS_WATCH = 2'd2,
    OCS_LATCH = 2'd3
  } oc_state_e;

endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/oc_win_counter.sv
module oc_win_counter #(
  parameter int WIN   = 8,
  parameter int CNT_W = $clog2(2*WIN+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(2*WIN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // clear parks the counter at saturation; load marks tick 1 of a sequence
  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = SAT;
    else if (load)                 cnt_d = CNT_W'(1);
    else if (adv && cnt_q != SAT)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SAT;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/oc_guard_fsm.sv
module oc_guard_fsm
  import oc_guard_pkg::*;
#(
  parameter int WIN   = 8,
  parameter int CNT_W = $clog2(2*WIN+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             oc,
  input  logic [CNT_W-1:0] cnt,
  output oc_state_e        state,
  output logic             cnt_clr,
  output logic             cnt_load,
  output logic             cnt_adv
);

  localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(WIN-1);
  localparam logic [CNT_W-1:0] WATCH_LAST = CNT_W'(2*WIN-1);

  oc_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cnt_clr  = !active;
    cnt_load = 1'b0;
    cnt_adv  = 1'b0;
    if (!active) begin
      st_d = OCS_REST;
    end else if (tick) begin
      unique case (st_q)
        OCS_REST: begin
          if (oc) begin
            st_d     = OCS_LIMIT;
            cnt_load = 1'b1;
          end
        end
        OCS_LIMIT: begin
          cnt_adv = 1'b1;
          if (cnt == LIMIT_LAST) st_d = OCS_WATCH;
        end
        OCS_WATCH: begin
          if (oc) begin
            st_d = OCS_LATCH;
          end else begin
            cnt_adv = 1'b1;
            if (cnt == WATCH_LAST) st_d = OCS_REST;
          end
        end
        OCS_LATCH: st_d = OCS_LATCH;
        default:   st_d = OCS_REST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= OCS_REST;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/oc_guard_timer.sv
module oc_guard_timer
  import oc_guard_pkg::*;
#(
  parameter int WIN          = 8,
  parameter int CHAN_W       = 1,
  parameter int DDR_OFF_CHAN = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_tick,
  input  logic              oc_hit,
  input  logic              ddr_mode,
  input  logic [CHAN_W-1:0] chan_id,
  output logic              skip_hs,
  output logic              fault_req
);

  localparam int CNT_W = $clog2(2*WIN+1);

  logic             srst_n;
  logic             chan_off;
  logic             active;
  logic             latched;
  logic [CNT_W-1:0] cnt_w;
  oc_state_e        st_w;
  logic             clr_w, load_w, adv_w;

  oc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign chan_off = ddr_mode && (chan_id == CHAN_W'(DDR_OFF_CHAN));
  assign active   = en && !chan_off;

  oc_guard_fsm #(.WIN(WIN), .CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .active   (active),
    .tick     (sw_tick),
    .oc       (oc_hit),
    .cnt      (cnt_w),
    .state    (st_w),
    .cnt_clr  (clr_w),
    .cnt_load (load_w),
    .cnt_adv  (adv_w)
  );

  oc_win_counter #(.WIN(WIN), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (clr_w),
    .load  (load_w),
    .adv   (adv_w),
    .cnt   (cnt_w)
  );

  assign latched   = (st_w == OCS_LATCH);
  assign fault_req = latched;
  assign skip_hs   = active && (oc_hit || latched);

endmodule

// File: rtl/oc_guard_checker.sv
module oc_guard_checker #(
  parameter int WIN          = 8,
  parameter int CHAN_W       = 1,
  parameter int DDR_OFF_CHAN = 1,
  parameter int CNT_W        = $clog2(2*WIN+1)
) (
  input logic              clk,
  input logic              srst_n,
  input logic              en,
  input logic              sw_tick,
  input logic              oc_hit,
  input logic              ddr_mode,
  input logic [CHAN_W-1:0] chan_id,
  input logic              skip_hs,
  input logic              fault_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [1:0]        st_q
);

  logic off_c;
  assign off_c = ddr_mode && (chan_id == CHAN_W'(DDR_OFF_CHAN));

  // R4: a latch only ever appears at the end of a tick cycle
  p_latch_on_tick_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(fault_req) |-> $past(sw_tick) && $past(oc_hit));

  // R6: latched fault persists while the channel stays enabled
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (fault_req && en && !off_c) |=> fault_req);

  // R6: latched channel keeps the high side off
  p_latch_skip_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (fault_req && en && !off_c) |-> skip_hs);

  // R7: enable low clears the latch at the edge
  p_en_clear_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> !fault_req);

  // R8: switched-off channel never skips and drops its latch
  p_ddr_quiet_r8: assert property (@(posedge clk) disable iff (!srst_n)
    off_c |=> !fault_req);

  // R5: the tick counter never passes its saturation value
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= CNT_W'(2*WIN));

  // R9: without a tick the sequence does not move
  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!sw_tick && en && !off_c) |=> ($stable(cnt_q) && $stable(st_q)));

endmodule

bind oc_guard_timer oc_guard_checker #(
  .WIN(WIN), .CHAN_W(CHAN_W), .DDR_OFF_CHAN(DDR_OFF_CHAN)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .en        (en),
  .sw_tick   (sw_tick),
  .oc_hit    (oc_hit),
  .ddr_mode  (ddr_mode),
  .chan_id   (chan_id),
  .skip_hs   (skip_hs),
  .fault_req (fault_req),
  .cnt_q     (cnt_w),
  .st_q      (st_w)
);

// File: tb/oc_guard_timer_test.sv
module oc_guard_timer_test;

  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, en, sw_tick, oc_hit, ddr_mode;
  logic [0:0] chan_id;
  logic skip_hs, fault_req;
  int   n_chk, n_err;

  oc_guard_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_tick(sw_tick), .oc_hit(oc_hit),
    .ddr_mode(ddr_mode), .chan_id(chan_id), .skip_hs(skip_hs), .fault_req(fault_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one switching-cycle tick; outputs sampled 1 unit after the edge
  task automatic step(input logic o);
    oc_hit = o; sw_tick = 1'b1;
    @(posedge clk); #1;
    sw_tick = 1'b0; oc_hit = 1'b0;
  endtask

  task automatic steps(input int n, input logic o);
    for (int i = 0; i < n; i++) step(o);
  endtask

  task automatic clear_en();
    en = 1'b0;
    @(posedge clk); #1;
    en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "skip after reset", skip_hs, 1'b0);
    chk("R1", "fault after reset", fault_req, 1'b0);
  endtask

  task automatic t_skip();
    oc_hit = 1'b1; #1;
    chk("R2", "skip with oc high", skip_hs, 1'b1);
    oc_hit = 1'b0; #1;
    chk("R2", "skip with oc low", skip_hs, 1'b0);
  endtask

  task automatic t_no_tick();
    oc_hit = 1'b1;
    repeat (20) @(posedge clk);
    #1 oc_hit = 1'b0;
    chk("R9", "no latch without ticks", fault_req, 1'b0);
  endtask

  task automatic t_window1();
    step(1'b1);
    steps(7, 1'b1);
    chk("R3", "oc through tick 8 no latch", fault_req, 1'b0);
    step(1'b1);
    chk("R4", "oc on tick 9 latches", fault_req, 1'b1);
    clear_en();
  endtask

  task automatic t_late();
    step(1'b1);
    steps(14, 1'b0);
    chk("R4", "clean through tick 15", fault_req, 1'b0);
    step(1'b1);
    chk("R4", "oc on tick 16 latches", fault_req, 1'b1);
    clear_en();
  endtask

  task automatic t_rearm();
    step(1'b1);
    steps(15, 1'b0);
    step(1'b1);
    chk("R5", "tick 17 trip is fresh", fault_req, 1'b0);
    steps(7, 1'b1);
    chk("R5", "fresh window1 no latch", fault_req, 1'b0);
    step(1'b1);
    chk("R5", "fresh tick 9 latches", fault_req, 1'b1);
  endtask

  task automatic t_latched();
    for (int i = 0; i < 6; i++) step(i[0]);
    chk("R6", "latch held under activity", fault_req, 1'b1);
    repeat (5) @(posedge clk);
    #1;
    chk("R6", "skip held with oc low", skip_hs, 1'b1);
  endtask

  task automatic t_enable();
    clear_en();
    chk("R7", "en low clears latch", fault_req, 1'b0);
    chk("R7", "skip low after clear", skip_hs, 1'b0);
    step(1'b1);
    steps(3, 1'b1);
    clear_en();
    steps(5, 1'b1);
    chk("R7", "sequence restarted after en", fault_req, 1'b0);
    clear_en();
  endtask

  task automatic t_ddr();
    ddr_mode = 1'b1; chan_id = 1'b1;
    oc_hit = 1'b1; #1;
    chk("R8", "off channel skip", skip_hs, 1'b0);
    oc_hit = 1'b0;
    steps(12, 1'b1);
    chk("R8", "off channel no latch", fault_req, 1'b0);
    chan_id = 1'b0;
    steps(9, 1'b1);
    chk("R8", "other channel still latches", fault_req, 1'b1);
    clear_en();
    ddr_mode = 1'b0; chan_id = 1'b1;
    steps(9, 1'b1);
    chk("R8", "channel 1 latches outside mode", fault_req, 1'b1);
    ddr_mode = 1'b1;
    @(posedge clk); #1;
    chk("R8", "mode entry clears channel 1", fault_req, 1'b0);
    ddr_mode = 1'b0; chan_id = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; en = 1'b1; sw_tick = 1'b0; oc_hit = 1'b0;
    ddr_mode = 1'b0; chan_id = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_skip();
    t_no_tick();
    t_window1();
    t_late();
    t_rearm();
    t_latched();
    t_enable();
    t_ddr();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule